// File: doc/BRIEF.md
# Indirect Auto-Increment Memory Access Port

This block gives a host a narrow window into two local memories through four 16-bit registers. The host first writes a control word and a halfword offset. It then reads or writes the data register over and over. Each data access reaches the halfword that the offset points to, and afterwards the offset moves forward by two bytes. A whole buffer can therefore be streamed without reloading the address.

One control bit chooses the memory behind the data register: the work RAM or the shared communication RAM. A second control bit drives the reset of the local processor. The block only issues requests on a simple memory request interface; the two memories sit outside it. Data writes finish in the cycle they are presented. A data read holds the host with a ready signal until the selected memory returns the data.

Top module: `ind_mem_port`

## Requirements
- R1: After reset the control register reads 0xC000, the offset reads 0, the status word output is 0, and the local processor is held in reset.
- R2: Host register index 0 is control, 1 is offset, 2 is data and 3 is the status word. Writes to index 3 appear on the status word output. Reads of index 0 and 1 return the current values. A read of index 3 returns 0.
- R3: The processor reset output `cpu_rst_n` equals control bit 5, so 1 releases the processor and 0 holds it in reset. It follows every control write.
- R4: A data write completes in the cycle it is presented, with `h_ready` high. In that cycle the block drives one memory write request carrying the host data at halfword address offset[15:1]. It then adds 2 to the offset.
- R5: A data read issues exactly one memory read request at halfword address offset[15:1] and keeps `h_ready` low until `m_rvalid`. In the `m_rvalid` cycle it returns `m_rdata` on `h_rdata` and then adds 2 to the offset. With a memory latency of L cycles, `h_ready` is low for exactly L cycles.
- R6: Control bit 0 selects the target of data accesses: 1 for the work RAM (`m_tgt`=1) and 0 for the shared communication RAM (`m_tgt`=0). The memory that is not selected is left untouched.
- R7: The offset wraps modulo 65536, so an access at 0xFFFE leaves 0x0000. An odd offset addresses the halfword offset[15:1] and stays odd after the increment.
- R8: Accesses to the control, offset and status registers make no memory request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_sel | input | 1 | Host access strobe, held until accepted |
| h_we | input | 1 | Host write (1) or read (0) |
| h_idx | input | 2 | Host register index |
| h_wdata | input | 16 | Host write data |
| h_rdata | output | 16 | Host read data, valid when h_ready |
| h_ready | output | 1 | Access completes at the clock edge where h_sel and h_ready are both high |
| m_req | output | 1 | Memory request, one cycle per access |
| m_we | output | 1 | Memory request is a write |
| m_tgt | output | 1 | Target memory: 1 work RAM, 0 communication RAM |
| m_addr | output | 15 | Halfword address |
| m_wdata | output | 16 | Memory write data |
| m_rvalid | input | 1 | Read data valid pulse |
| m_rdata | input | 16 | Memory read data |
| cpu_rst_n | output | 1 | Local processor reset, low holds |
| stat0 | output | 16 | Status word 0 |

## Verification
A wrong offset shows up on `m_addr` at the next data access, and on `h_rdata` when the host reads the offset back. A wrong target bit puts data into the other memory, and the next read returns the wrong value. A stuck wait state either starves `h_ready`, which the per-access cycle limit catches within a few cycles, or raises it before `m_rvalid`, which the exact-latency check catches on the same access.

// File: rtl/ind_mem_port.sv
module ind_mem_port #(
  parameter int DW = 16,
  parameter int OFS_W = 16,
  parameter logic [15:0] CTRL_RST = 16'hC000,
  parameter int SEL_BIT = 0,
  parameter int RUN_BIT = 5,
  localparam int AW = OFS_W - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          h_sel,
  input  logic          h_we,
  input  logic [1:0]    h_idx,
  input  logic [DW-1:0] h_wdata,
  output logic [DW-1:0] h_rdata,
  output logic          h_ready,
  output logic          m_req,
  output logic          m_we,
  output logic          m_tgt,
  output logic [AW-1:0] m_addr,
  output logic [DW-1:0] m_wdata,
  input  logic          m_rvalid,
  input  logic [DW-1:0] m_rdata,
  output logic          cpu_rst_n,
  output logic [DW-1:0] stat0
);
  localparam logic [1:0] IX_CTRL = 2'd0;
  localparam logic [1:0] IX_OFS  = 2'd1;
  localparam logic [1:0] IX_DATA = 2'd2;
  localparam logic [1:0] IX_STAT = 2'd3;
  localparam logic [OFS_W-1:0] STEP = OFS_W'(2);

  logic [DW-1:0]    ctrl;
  logic [DW-1:0]    st0;
  logic [OFS_W-1:0] ofs;
  logic             busy;

  wire data_acc = h_sel && (h_idx == IX_DATA);
  wire done     = h_sel && h_ready;

  assign m_req     = data_acc && !busy;
  assign m_we      = h_we;
  assign m_tgt     = ctrl[SEL_BIT];
  assign m_addr    = ofs[OFS_W-1:1];
  assign m_wdata   = h_wdata;
  assign h_ready   = busy ? m_rvalid : !(data_acc && !h_we);
  assign cpu_rst_n = ctrl[RUN_BIT];
  assign stat0     = st0;

  always_comb begin
    case (h_idx)
      IX_CTRL: h_rdata = ctrl;
      IX_OFS:  h_rdata = DW'(ofs);
      IX_DATA: h_rdata = m_rdata;
      default: h_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= DW'(CTRL_RST);
      st0  <= '0;
      ofs  <= '0;
      busy <= 1'b0;
    end else begin
      if (busy) busy <= !m_rvalid;
      else      busy <= m_req && !m_we;
      if (done && h_we) begin
        case (h_idx)
          IX_CTRL: ctrl <= h_wdata;
          IX_OFS:  ofs  <= h_wdata[OFS_W-1:0];
          IX_STAT: st0  <= h_wdata;
          default: ;
        endcase
      end
      if (done && data_acc) ofs <= ofs + STEP;
    end
  end

  // R3: processor reset tracks the written control bit
  a_r3_run_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (done && h_we && h_idx == IX_CTRL) |=> (cpu_rst_n == $past(h_wdata[RUN_BIT])));

  // R4: a data write is accepted at once and advances the offset
  a_r4_wr_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (data_acc && h_we) |-> (h_ready && m_req) ##1 (ofs == $past(ofs) + STEP));

  // R5: a read stalls the host and requests only once
  a_r5_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && !m_we) |-> !h_ready);
  a_r5_single_req: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && !m_we) |=> !m_req);

  // R7: wrap from the top halfword
  a_r7_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (done && data_acc && ofs == {OFS_W{1'b1}} - 1'b1) |=> (ofs == '0));

  // R8: register accesses never reach memory
  a_r8_no_req_regs: assert property (@(posedge clk) disable iff (!rst_n)
    (h_sel && h_idx != IX_DATA) |-> !m_req);
endmodule

// File: tb/ind_mem_port_bench.sv
`timescale 1ns/1ps
module ind_mem_port_bench;
  logic clk = 0, rst_n = 0;
  logic h_sel = 0, h_we = 0;
  logic [1:0] h_idx = 0;
  logic [15:0] h_wdata = 0, h_rdata;
  logic h_ready, m_req, m_we, m_tgt, cpu_rst_n;
  logic [14:0] m_addr;
  logic [15:0] m_wdata, m_rdata = 0, stat0;
  logic m_rvalid = 0;

  always #2.5 clk = ~clk;

  ind_mem_port u_ind_mem_port (
    .clk(clk), .rst_n(rst_n), .h_sel(h_sel), .h_we(h_we), .h_idx(h_idx),
    .h_wdata(h_wdata), .h_rdata(h_rdata), .h_ready(h_ready),
    .m_req(m_req), .m_we(m_we), .m_tgt(m_tgt), .m_addr(m_addr),
    .m_wdata(m_wdata), .m_rvalid(m_rvalid), .m_rdata(m_rdata),
    .cpu_rst_n(cpu_rst_n), .stat0(stat0));

  int n_run = 0, n_fail = 0;
  int lat = 1, req_cnt = 0, stall_cnt = 0;
  logic [15:0] mem_w [int];
  logic [15:0] mem_c [int];
  logic [15:0] sh_w [int];
  logic [15:0] sh_c [int];
  logic [15:0] exp_q [$];
  string tag_q [$];
  logic [15:0] b_ofs = 0, b_ctrl = 16'hC000;

  function automatic logic [15:0] init_val(input logic t, input int a);
    return 16'(a) ^ (t ? 16'hA5A5 : 16'h5A5A);
  endfunction

  function automatic logic [15:0] rd_mem(input logic t, input int a);
    if (t) return mem_w.exists(a) ? mem_w[a] : init_val(1'b1, a);
    return mem_c.exists(a) ? mem_c[a] : init_val(1'b0, a);
  endfunction

  function automatic logic [15:0] rd_sh(input logic t, input int a);
    if (t) return sh_w.exists(a) ? sh_w[a] : init_val(1'b1, a);
    return sh_c.exists(a) ? sh_c[a] : init_val(1'b0, a);
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // memory model
  initial begin
    int cnt = 0;
    logic [15:0] pend = 0;
    forever begin
      @(negedge clk);
      m_rvalid = 0;
      if (cnt == 1) begin m_rvalid = 1; m_rdata = pend; end
      if (cnt > 0) cnt--;
      #0.5;
      if (m_req && rst_n) begin
        req_cnt++;
        if (m_we) begin
          if (m_tgt) mem_w[int'(m_addr)] = m_wdata;
          else       mem_c[int'(m_addr)] = m_wdata;
        end else begin
          pend = rd_mem(m_tgt, int'(m_addr));
          cnt = lat;
        end
      end
    end
  end

  // monitor: pops expected host read data
  initial begin
    forever begin
      @(negedge clk);
      #1.5;
      if (rst_n && h_sel && !h_we && h_ready) begin
        if (exp_q.size() == 0) begin
          n_run++; n_fail++;
          $display("FAIL R2: unexpected read result %h expected none", h_rdata);
        end else check(tag_q.pop_front(), h_rdata, exp_q.pop_front());
      end
    end
  end

  task automatic access(input logic we, input logic [1:0] idx, input logic [15:0] wd,
                        input string tag);
    int guard = 0;
    if (!we) begin
      case (idx)
        2'd0: exp_q.push_back(b_ctrl);
        2'd1: exp_q.push_back(b_ofs);
        2'd2: exp_q.push_back(rd_sh(b_ctrl[0], int'(b_ofs[15:1])));
        default: exp_q.push_back(16'h0000);
      endcase
      tag_q.push_back(tag);
    end
    @(negedge clk);
    h_sel = 1; h_we = we; h_idx = idx; h_wdata = wd;
    stall_cnt = 0;
    forever begin
      #1;
      if (h_ready) break;
      stall_cnt++; guard++;
      if (guard > 20) begin
        n_run++; n_fail++;
        $display("FAIL %s: h_ready never rose actual 0 expected 1", tag);
        break;
      end
      @(negedge clk);
    end
    @(posedge clk);
    if (we) begin
      case (idx)
        2'd0: b_ctrl = wd;
        2'd1: b_ofs = wd;
        2'd2: if (b_ctrl[0]) sh_w[int'(b_ofs[15:1])] = wd; else sh_c[int'(b_ofs[15:1])] = wd;
        default: ;
      endcase
    end
    if (idx == 2'd2) b_ofs = b_ofs + 16'd2;
    #0.1;
    h_sel = 0; h_we = 0;
  endtask

  initial begin
    #(200000 * 5);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int r0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 cpu held", 16'(cpu_rst_n), 16'h0);
    check("R1 stat0", stat0, 16'h0);
    access(0, 2'd0, 0, "R1 ctrl reset");
    access(0, 2'd1, 0, "R1 offset reset");
    // R2 registers, R8 no memory traffic
    r0 = req_cnt;
    access(1, 2'd1, 16'h0010, "R2");
    access(0, 2'd1, 0, "R2 offset readback");
    access(1, 2'd3, 16'hBEEF, "R2");
    @(negedge clk);
    check("R2 stat0 write", stat0, 16'hBEEF);
    access(0, 2'd3, 0, "R2 index3 reads 0");
    // R3 processor reset bit
    access(1, 2'd0, 16'h0001, "R3");
    @(negedge clk);
    check("R3 held", 16'(cpu_rst_n), 16'h0);
    access(0, 2'd0, 0, "R2 ctrl readback");
    access(1, 2'd0, 16'h0021, "R3");
    @(negedge clk);
    check("R3 released", 16'(cpu_rst_n), 16'h1);
    check("R8 no requests on registers", 16'(req_cnt - r0), 16'h0);
    // R4 / R6 writes to work RAM
    r0 = req_cnt;
    for (int i = 0; i < 3; i++) begin
      access(1, 2'd2, 16'h1000 + 16'(i), "R4");
      check("R4 write no stall", 16'(stall_cnt), 16'h0);
    end
    check("R4 one request per write", 16'(req_cnt - r0), 16'h3);
    check("R4 work RAM word 8", rd_mem(1'b1, 8), 16'h1000);
    check("R4 work RAM word 10", rd_mem(1'b1, 10), 16'h1002);
    access(0, 2'd1, 0, "R4 offset advanced");
    // R6 communication RAM
    access(1, 2'd0, 16'h0020, "R6");
    access(1, 2'd1, 16'h0010, "R6");
    access(1, 2'd2, 16'h2000, "R6");
    access(1, 2'd2, 16'h2001, "R6");
    check("R6 comm RAM word 8", rd_mem(1'b0, 8), 16'h2000);
    check("R6 comm RAM word 9", rd_mem(1'b0, 9), 16'h2001);
    check("R6 work RAM untouched", rd_mem(1'b1, 8), 16'h1000);
    // R5 reads with various latency, R6 selection
    access(1, 2'd0, 16'h0021, "R5");
    access(1, 2'd1, 16'h000E, "R5");
    for (int l = 1; l <= 4; l++) begin
      lat = l;
      r0 = req_cnt;
      access(0, 2'd2, 0, "R5 read data");
      check("R5 stall cycles", 16'(stall_cnt), 16'(l));
      check("R5 single request", 16'(req_cnt - r0), 16'h1);
    end
    access(0, 2'd1, 0, "R5 offset after reads");
    access(1, 2'd0, 16'h0020, "R6");
    access(1, 2'd1, 16'h0010, "R6");
    lat = 2;
    access(0, 2'd2, 0, "R6 comm read");
    access(0, 2'd2, 0, "R6 comm read");
    // R7 wrap and odd offset
    access(1, 2'd1, 16'hFFFE, "R7");
    access(1, 2'd2, 16'h7777, "R7");
    check("R7 top halfword", rd_mem(1'b0, 32767), 16'h7777);
    access(0, 2'd1, 0, "R7 wrapped offset");
    access(1, 2'd1, 16'h0005, "R7");
    access(1, 2'd2, 16'h5555, "R7");
    check("R7 odd offset address", rd_mem(1'b0, 2), 16'h5555);
    access(0, 2'd1, 0, "R7 odd offset stays odd");
    access(1, 2'd1, 16'hFFFE, "R7");
    lat = 1;
    access(0, 2'd2, 0, "R7 read top");
    access(0, 2'd1, 0, "R7 wrap after read");
    repeat (3) @(negedge clk);
    check("R2 scoreboard drained", 16'(exp_q.size()), 16'h0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule